// File: doc/BRIEF.md
# Presettable Cascadable Synchronous Counter

This block is a chain of 4-bit counting stages that share one clock. Each stage counts in binary (0 to 15) or in decade (0 to 9), upward or downward. Every stage responds to an active-low synchronous clear, an active-low synchronous parallel load, and two count enables. One enable is shared by all stages. The other enters the lowest stage and then travels from stage to stage through each stage's terminal-count carry. The chained stages therefore form a wide binary counter, or a multi-digit BCD counter when the decade mode is selected.

The terminal-count carry depends on direction. When counting up, it marks the top value of the digit (9 or 15). When counting down, it marks zero. It is also gated by the chained enable. The carry of the last stage leaves the block so that more chains can be attached. A cyclic range, such as 5 through 10, is built by pulling the load low at the last value of the range, with the first value of the range on the data inputs.

Top module: `cnt_chain`

## Requirements
- R1: While clear_n is low at a rising edge, every digit becomes 0 at that edge. Clear takes priority over load and over counting.
- R2: While load_n is low and clear_n is high at a rising edge, count takes load_val at that edge. This happens even when both enables are low. Nibble i of load_val goes to stage i, and bit 3 of each nibble is that digit's most significant bit.
- R3: When load_n and clear_n are both high, the count advances only if en_all is high and the chained enable reaching that stage is high. Otherwise the count holds its value.
- R4: In binary mode (mode_dec=0) counting up, a digit steps by one and goes from 15 to 0.
- R5: In decade mode (mode_dec=1) counting up, a digit goes from 9 to 0. A digit loaded with a value above 9 goes to 0 on its next enabled count.
- R6: Counting down (dir_up=0), a digit steps down by one and goes from 0 to 15 in binary mode or from 0 to 9 in decade mode. In decade mode, a digit above 9 goes to 0.
- R7: The carry of a stage is high exactly when its chained enable is high and its digit is at the terminal value: the top value (9 or 15) when counting up, and 0 when counting down.
- R8: With the stages chained, count behaves as one counter. In binary mode it is a 2^(4·NSTAGES) counter. In decade mode it is a BCD counter of NSTAGES digits.
- R9: carry_out is high exactly when en_chain is high and every digit is at its terminal value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clear_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_all | input | 1 | Count enable shared by every stage |
| en_chain | input | 1 | Count enable into the lowest stage, passed upward by carries |
| dir_up | input | 1 | 1 counts up, 0 counts down |
| mode_dec | input | 1 | 1 selects decade digits, 0 binary digits |
| load_val | input | 4·NSTAGES | Parallel load word, nibble i for stage i |
| count | output | 4·NSTAGES | Current count, nibble i from stage i |
| carry_out | output | 1 | Terminal-count carry of the last stage |

## Verification
Clear, load and counting all take effect at the first rising edge that samples them, so count is due one edge after the stimulus. carry_out is combinational from the registered digits and en_chain, so it is due in the same cycle as the digits it reflects. The bench drives inputs at the falling edge and advances its behavioural model at the rising edge. It compares count and carry_out at the next falling edge, once per clock, in binary and decade mode, up and down. It also covers loads above 9, clear over load, enable gating, long chained runs and a 5-to-10 reload loop.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int DIG_W = 4;
    localparam logic [DIG_W-1:0] BIN_TOP = 4'd15;
    localparam logic [DIG_W-1:0] DEC_TOP = 4'd9;

    typedef struct packed {
        logic [DIG_W-1:0] cnt;
    } stage_t;

endpackage

// File: rtl/cnt_limit.sv
module cnt_limit
    import cnt_pkg::*;
(
    input  logic [DIG_W-1:0] cnt,
    input  logic             mode_dec,
    input  logic             dir_up,
    output logic [DIG_W-1:0] top,
    output logic             at_term,
    output logic             at_or_over,
    output logic             dec_bad
);

    always_comb begin
        top        = mode_dec ? DEC_TOP : BIN_TOP;
        at_term    = dir_up ? (cnt == top) : (cnt == '0);
        at_or_over = (cnt >= top);
        dec_bad    = mode_dec && (cnt > DEC_TOP);
    end

endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
(
    input  logic             clk,
    input  logic             clear_n,
    input  logic             load_n,
    input  logic             en_all,
    input  logic             en_in,
    input  logic             dir_up,
    input  logic             mode_dec,
    input  logic [DIG_W-1:0] load_val,
    output logic [DIG_W-1:0] cnt,
    output logic             carry
);

    stage_t st_d, st_q;
    logic [DIG_W-1:0] top;
    logic at_term, at_or_over, dec_bad, step;

    cnt_limit u_limit (
        .cnt        (st_q.cnt),
        .mode_dec   (mode_dec),
        .dir_up     (dir_up),
        .top        (top),
        .at_term    (at_term),
        .at_or_over (at_or_over),
        .dec_bad    (dec_bad)
    );

    assign step = en_all && en_in;

    always_comb begin
        st_d = st_q;
        if (!clear_n) begin
            st_d.cnt = '0;
        end else if (!load_n) begin
            st_d.cnt = load_val;
        end else if (step) begin
            if (dir_up) begin
                st_d.cnt = at_or_over ? '0 : st_q.cnt + 1'b1;
            end else if (dec_bad) begin
                st_d.cnt = '0;
            end else if (st_q.cnt == '0) begin
                st_d.cnt = top;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign carry = en_in && at_term;

    // R1: clear forces zero at the next edge
    a_r1_clear_zero: assert property (@(posedge clk)
        !clear_n |=> (cnt == '0));

    // R2: load copies the word regardless of enables
    a_r2_load_copies: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> (cnt == $past(load_val)));

    // R3: no enable, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(en_all && en_in)) |=> $stable(cnt));

    // R4 / R5: upward wrap at the top value
    a_r5_up_wrap: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && step && dir_up && (cnt == (mode_dec ? DEC_TOP : BIN_TOP))) |=> (cnt == '0));

    // R6: downward wrap from zero
    a_r6_down_wrap: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && step && !dir_up && (cnt == '0)) |=>
        (cnt == ($past(mode_dec) ? DEC_TOP : BIN_TOP)));

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int NSTAGES = 2,
    localparam int W = NSTAGES * DIG_W
) (
    input  logic         clk,
    input  logic         clear_n,
    input  logic         load_n,
    input  logic         en_all,
    input  logic         en_chain,
    input  logic         dir_up,
    input  logic         mode_dec,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] count,
    output logic         carry_out
);

    logic [NSTAGES:0] link;

    assign link[0] = en_chain;

    for (genvar i = 0; i < NSTAGES; i++) begin : g_stage
        cnt_stage u_stage (
            .clk      (clk),
            .clear_n  (clear_n),
            .load_n   (load_n),
            .en_all   (en_all),
            .en_in    (link[i]),
            .dir_up   (dir_up),
            .mode_dec (mode_dec),
            .load_val (load_val[i*DIG_W +: DIG_W]),
            .cnt      (count[i*DIG_W +: DIG_W]),
            .carry    (link[i+1])
        );
    end

    assign carry_out = link[NSTAGES];

    logic all_term;
    always_comb begin
        all_term = 1'b1;
        for (int i = 0; i < NSTAGES; i++) begin
            if (dir_up)
                all_term = all_term && (count[i*DIG_W +: DIG_W] == (mode_dec ? DEC_TOP : BIN_TOP));
            else
                all_term = all_term && (count[i*DIG_W +: DIG_W] == '0);
        end
    end

    // R9: chain carry only at the whole-count extreme with the chain enabled
    a_r9_carry_extreme: assert property (@(posedge clk) disable iff (!clear_n)
        carry_out |-> (all_term && en_chain));

endmodule

// File: tb/cnt_chain_bench.sv
`timescale 1ns/1ps
module cnt_chain_bench;

    localparam int NST = 2;
    localparam int W   = NST * 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         clear_n  = 1'b0;
    logic         load_n   = 1'b1;
    logic         en_all   = 1'b0;
    logic         en_chain = 1'b0;
    logic         dir_up   = 1'b1;
    logic         mode_dec = 1'b0;
    logic [W-1:0] load_val = '0;
    logic [W-1:0] count;
    logic         carry_out;

    cnt_chain #(.NSTAGES(NST)) u_cnt_chain (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .en_all(en_all),
        .en_chain(en_chain), .dir_up(dir_up), .mode_dec(mode_dec),
        .load_val(load_val), .count(count), .carry_out(carry_out)
    );

    int    rd[NST];
    int    errs   = 0;
    int    checks = 0;
    string req    = "R1";

    function automatic int topv();
        return mode_dec ? 9 : 15;
    endfunction

    function automatic bit term(int d);
        return dir_up ? (d == topv()) : (d == 0);
    endfunction

    task automatic ref_update();
        bit c;
        if (!clear_n) begin
            for (int i = 0; i < NST; i++) rd[i] = 0;
        end else if (!load_n) begin
            for (int i = 0; i < NST; i++) rd[i] = int'(load_val[i*4 +: 4]);
        end else begin
            c = en_chain;
            for (int i = 0; i < NST; i++) begin
                bit nc;
                nc = c && term(rd[i]);
                if (c && en_all) begin
                    if (dir_up) rd[i] = (rd[i] >= topv()) ? 0 : rd[i] + 1;
                    else if (mode_dec && rd[i] > 9) rd[i] = 0;
                    else if (rd[i] == 0) rd[i] = topv();
                    else rd[i] = rd[i] - 1;
                end
                c = nc;
            end
        end
    endtask

    task automatic check(bit ok, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [W-1:0] ev;
        bit c;
        c = en_chain;
        for (int i = 0; i < NST; i++) begin
            ev[i*4 +: 4] = rd[i][3:0];
            c = c && term(rd[i]);
        end
        check(count === ev, "count", count, ev);
        check(carry_out === c, "carry_out", {{(W-1){1'b0}}, carry_out}, {{(W-1){1'b0}}, c});
    endtask

    task automatic tick(int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            ref_update();
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        #(200000 * 10);
        errs++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R1: clear wins over load and count
        req = "R1"; load_n = 1'b0; load_val = 8'hAA; en_all = 1'b1; en_chain = 1'b1;
        tick(3);
        // R2: load with enables low, nibble and bit order
        req = "R2"; clear_n = 1'b1; en_all = 1'b0; en_chain = 1'b0; load_val = 8'h3C;
        tick(1);
        load_val = 8'h81; tick(1);
        // R3: enable gating
        req = "R3"; load_n = 1'b1; en_all = 1'b0; en_chain = 1'b1; tick(4);
        en_all = 1'b1; en_chain = 1'b0; tick(4);
        en_chain = 1'b1; tick(3);
        // R4 and R9: binary up across the full wrap
        req = "R4"; load_n = 1'b0; load_val = 8'hFD; tick(1);
        load_n = 1'b1; tick(6);
        // R6: binary down through zero
        req = "R6"; dir_up = 1'b0; load_n = 1'b0; load_val = 8'h02; tick(1);
        load_n = 1'b1; tick(5);
        // R5: decade up across 99 -> 00
        req = "R5"; dir_up = 1'b1; mode_dec = 1'b1; load_n = 1'b0; load_val = 8'h97; tick(1);
        load_n = 1'b1; tick(15);
        // R5: digit above nine
        load_n = 1'b0; load_val = 8'h0C; tick(1);
        load_n = 1'b1; tick(3);
        // R6: decade down through 00 -> 99, and an out-of-range digit
        req = "R6"; dir_up = 1'b0; load_n = 1'b0; load_val = 8'h01; tick(1);
        load_n = 1'b1; tick(4);
        load_n = 1'b0; load_val = 8'h0E; tick(1);
        load_n = 1'b1; tick(2);
        // R7: chained enable low masks carry at terminal value
        req = "R7"; load_n = 1'b0; load_val = 8'h00; tick(1);
        load_n = 1'b1; en_all = 1'b0; en_chain = 1'b0; tick(2);
        en_chain = 1'b1; tick(2);
        // R8: long chained runs with gaps in both enables
        req = "R8"; mode_dec = 1'b0; dir_up = 1'b1; en_all = 1'b1;
        load_n = 1'b0; load_val = 8'h00; tick(1);
        load_n = 1'b1;
        for (int i = 0; i < 300; i++) begin
            en_all = (i % 7) != 3;
            en_chain = (i % 11) != 5;
            tick(1);
        end
        mode_dec = 1'b1; load_n = 1'b0; load_val = 8'h00; tick(1);
        load_n = 1'b1;
        for (int i = 0; i < 150; i++) begin
            en_all = (i % 5) != 2;
            en_chain = 1'b1;
            tick(1);
        end
        dir_up = 1'b0;
        for (int i = 0; i < 60; i++) begin
            en_all = 1'b1;
            en_chain = (i % 9) != 4;
            tick(1);
        end
        // R1: clear mid-count with load also low
        req = "R1"; load_n = 1'b0; load_val = 8'h55; clear_n = 1'b0; tick(1);
        clear_n = 1'b1; load_n = 1'b1; tick(1);
        // R2: cyclic 5..10 by reload at 10
        req = "R2"; mode_dec = 1'b0; dir_up = 1'b1; en_all = 1'b1; en_chain = 1'b1;
        load_n = 1'b0; load_val = 8'h05; tick(1);
        for (int i = 0; i < 20; i++) begin
            load_n = (count[3:0] == 4'd10) ? 1'b0 : 1'b1;
            tick(1);
            check((count >= 8'h05) && (count <= 8'h0A), "range5to10", count, 8'h05);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule